// File: doc/BRIEF.md
# Gate Driver Fault Protection Sequencer

This block is the digital control core of an isolated gate driver for a power transistor. It decides when the transistor gate may be driven on and when it must be held off, and it runs the protection sequence that follows a collector-voltage desaturation event. Analog comparators, current sources, isolation and output stages sit outside the block. They reach it as single-bit flags, sampled on the block's clock: the gate command, the desaturation comparator, a flag for a gate voltage near the negative rail, and two supply comparators (rising and falling thresholds).

After each turn-on the block waits out a blanking window before it believes the desaturation comparator. A desaturation event while the gate is on starts a soft shutdown through the weak discharge path only. The strong pull-down takes over once the gate has fallen near the rail. The active-low fault flag is held for a self-timed mute period, and the command is ignored for all of it. When the period ends, the flag releases by itself. The gate then stays off until the command has been seen low again.

A supply lockout with hysteresis holds the gate off while the driver supply is too low. A Miller clamp enable grips the gate once it has fallen below the low threshold while off, and drops as the gate turns on again. All durations are parameters counted in clock cycles: BLANK_CYC for the blanking window and MUTE_CYC for the mute time.

Top module: `gate_fault_sequencer`

## Requirements
- R1: gate_en is high only while cmd_on was high at the sampling edge, the lockout is released and no fault is being handled. A low cmd_on, or an engaged lockout, seen at an edge makes gate_en low after that edge.
- R2: fault_n is high in normal operation. It is low from the edge at which a desaturation fault is taken until the fault period ends.
- R3: When gate_en rises, desat_hi is ignored at the first BLANK_CYC sampling edges. It is honoured from the next edge on.
- R4: When a fault is taken, the block enters soft shutdown: soft_dis_en=1, hard_pd_en=0 and gate_en=0.
- R5: In soft shutdown, gate_below_lo=1 at an edge moves the block to hard clamp: hard_pd_en=1 and soft_dis_en=0 after that edge.
- R6: cmd_on has no effect for the whole fault period, and gate_en stays 0 throughout.
- R7: fault_n returns high by itself. This happens MUTE_CYC cycles after the detection edge if hard clamp was reached by then. Otherwise it happens one cycle after hard clamp is reached, so the soft shutdown always completes.
- R8: While the gate is off, gate_below_lo=1 at an edge sets clamp_en after that edge. clamp_en clears in the same cycle in which gate_en rises, and it is never high together with gate_en.
- R9: The lockout engages one edge after sup_below_lo=1 and releases one edge after sup_above_hi=1 with sup_below_lo=0. With both flags low it holds its state, and sup_below_lo wins when both are high.
- R10: After a fault releases, gate_en stays 0 while cmd_on stays high. Only after cmd_on has been sampled low can a new turn-on happen.
- R11: desat_hi while the gate is off, or inside the blanking window, leaves fault_n high and soft_dis_en low.
- R12: After reset, gate_en=0, fault_n=1, clamp_en=1, soft_dis_en=0 and hard_pd_en=0, with the lockout engaged and both timers cleared.
- R13: If desat_hi=1 and cmd_on=0 are sampled at the same edge while the gate is on past blanking, the fault is taken (fault_n=0, soft_dis_en=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_on | input | 1 | Synchronized gate command, 1 = on |
| desat_hi | input | 1 | Desaturation comparator flag |
| gate_below_lo | input | 1 | Gate voltage is below the low threshold near the negative rail |
| sup_above_hi | input | 1 | Supply is above the rising lockout threshold |
| sup_below_lo | input | 1 | Supply is below the falling lockout threshold |
| gate_en | output | 1 | Main gate drive enable |
| soft_dis_en | output | 1 | Weak soft-discharge enable |
| hard_pd_en | output | 1 | Strong pull-down enable |
| clamp_en | output | 1 | Miller clamp enable |
| fault_n | output | 1 | Fault flag, active low |

## Verification
Two events can coincide at one edge. The first pair is a desaturation event and a command turn-off, sampled together while the gate is on. The bench provokes this on purpose and expects the fault to be taken rather than a plain turn-off. The second pair is the end of the mute count and the arrival of gate_below_lo. The bench holds the flag low past the mute length and expects fault_n to stay low until one cycle after hard clamp. In a second case it raises the flag at once and expects the exact MUTE_CYC length. Random stimulus makes both coincidences, and lockout changes against blanking, happen many more times, and a cycle model in the bench judges every output on every cycle.

// File: rtl/gfs_pkg.sv
package gfs_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_BLANK,
    ST_ON,
    ST_SOFT,
    ST_HARD,
    ST_REARM
  } gfs_state_t;

  // gate drive is enabled in these states
  function automatic logic gfs_drives_gate(input gfs_state_t s);
    return (s == ST_BLANK) || (s == ST_ON);
  endfunction

  // fault period: soft discharge or hard clamp
  function automatic logic gfs_in_fault(input gfs_state_t s);
    return (s == ST_SOFT) || (s == ST_HARD);
  endfunction

  // counter width that holds values 0 .. limit-1
  function automatic int gfs_cnt_width(input int limit);
    return (limit > 2) ? $clog2(limit) : 1;
  endfunction
endpackage

// File: rtl/gfs_timer.sv
module gfs_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic done
);
  import gfs_pkg::*;
  localparam int W = gfs_cnt_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign done = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (run && !done) cnt <= cnt + 1'b1;
  end

  // R7
  tmr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && done) |=> done);
  // R7
  tmr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/gfs_uvlo.sv
module gfs_uvlo (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_above_hi,
  input  logic sup_below_lo,
  output logic lock
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            lock <= 1'b1;
    else if (sup_below_lo) lock <= 1'b1;
    else if (sup_above_hi) lock <= 1'b0;
  end

  // R9
  uv_engage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sup_below_lo |=> lock);
  // R9
  uv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_below_lo && !sup_above_hi) |=> $stable(lock));
endmodule

// File: rtl/gfs_seq.sv
module gfs_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_on,
  input  logic desat_hi,
  input  logic gate_below_lo,
  input  logic lock,
  input  logic blank_done,
  input  logic mute_done,
  output logic blank_clr,
  output logic blank_run,
  output logic mute_clr,
  output logic mute_run,
  output logic gate_en,
  output logic soft_dis_en,
  output logic hard_pd_en,
  output logic clamp_en,
  output logic fault_n
);
  import gfs_pkg::*;

  gfs_state_t state, nxt;
  logic clamp_q;

  // named internal events
  logic desat_hit;   // desaturation accepted while on past blanking
  logic turn_off;    // command or lockout removes the gate
  logic rearm_wait;  // fault released, waiting for a low command

  assign desat_hit  = (state == ST_ON) && desat_hi;
  assign turn_off   = !cmd_on || lock;
  assign rearm_wait = (state == ST_REARM);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_OFF:   if (cmd_on && !lock) nxt = ST_BLANK;
      ST_BLANK: if (turn_off) nxt = ST_OFF;
                else if (blank_done) nxt = ST_ON;
      ST_ON:    if (desat_hit) nxt = ST_SOFT;
                else if (turn_off) nxt = ST_OFF;
      ST_SOFT:  if (gate_below_lo) nxt = ST_HARD;
      ST_HARD:  if (mute_done) nxt = ST_REARM;
      ST_REARM: if (!cmd_on) nxt = ST_OFF;
      default:  nxt = ST_OFF;
    endcase
  end

  assign blank_clr = (state == ST_OFF) && (nxt == ST_BLANK);
  assign blank_run = (state == ST_BLANK);
  assign mute_clr  = desat_hit;
  assign mute_run  = gfs_in_fault(state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_OFF;
      clamp_q <= 1'b1;
    end else begin
      state <= nxt;
      if (gfs_drives_gate(nxt)) clamp_q <= 1'b0;
      else if (gate_below_lo)   clamp_q <= 1'b1;
    end
  end

  assign gate_en     = gfs_drives_gate(state);
  assign soft_dis_en = (state == ST_SOFT);
  assign hard_pd_en  = (state == ST_HARD);
  assign clamp_en    = clamp_q;
  assign fault_n     = !gfs_in_fault(state);

  // R1
  lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> !gate_en);
  // R4
  soft_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_dis_en |-> (!hard_pd_en && !gate_en));
  // R5
  hard_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hard_pd_en) |-> ($past(gate_below_lo) && $past(soft_dis_en)));
  // R6
  fault_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |=> !gate_en);
  // R8
  clamp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_en |-> !gate_en);
  // R10
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_wait && cmd_on) |=> !gate_en);
  // R11
  blank_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_run || !gate_en) && fault_n |=> fault_n);
endmodule

// File: rtl/gate_fault_sequencer.sv
module gate_fault_sequencer #(
  parameter int BLANK_CYC = 8,
  parameter int MUTE_CYC  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_on,
  input  logic desat_hi,
  input  logic gate_below_lo,
  input  logic sup_above_hi,
  input  logic sup_below_lo,
  output logic gate_en,
  output logic soft_dis_en,
  output logic hard_pd_en,
  output logic clamp_en,
  output logic fault_n
);
  logic lock;
  logic blank_clr, blank_run, blank_done;
  logic mute_clr, mute_run, mute_done;

  gfs_uvlo uvlo_i (
    .clk(clk), .rst_n(rst_n),
    .sup_above_hi(sup_above_hi), .sup_below_lo(sup_below_lo),
    .lock(lock)
  );

  gfs_timer #(.LIMIT(BLANK_CYC)) blank_tmr_i (
    .clk(clk), .rst_n(rst_n), .clr(blank_clr), .run(blank_run), .done(blank_done)
  );

  gfs_timer #(.LIMIT(MUTE_CYC)) mute_tmr_i (
    .clk(clk), .rst_n(rst_n), .clr(mute_clr), .run(mute_run), .done(mute_done)
  );

  gfs_seq seq_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_on(cmd_on), .desat_hi(desat_hi), .gate_below_lo(gate_below_lo),
    .lock(lock), .blank_done(blank_done), .mute_done(mute_done),
    .blank_clr(blank_clr), .blank_run(blank_run),
    .mute_clr(mute_clr), .mute_run(mute_run),
    .gate_en(gate_en), .soft_dis_en(soft_dis_en), .hard_pd_en(hard_pd_en),
    .clamp_en(clamp_en), .fault_n(fault_n)
  );

  initial begin
    // R3
    blank_len_chk: assert (BLANK_CYC >= 1);
    // R7
    mute_len_chk: assert (MUTE_CYC >= 2);
  end
endmodule

// File: tb/gate_fault_sequencer_tb.sv
module gate_fault_sequencer_tb_top;
  localparam int BLANK = 8;
  localparam int MUTE  = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_on = 0, desat_hi = 0, gate_below_lo = 0, sup_above_hi = 0, sup_below_lo = 0;
  logic gate_en, soft_dis_en, hard_pd_en, clamp_en, fault_n;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  gate_fault_sequencer #(.BLANK_CYC(BLANK), .MUTE_CYC(MUTE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .desat_hi(desat_hi),
    .gate_below_lo(gate_below_lo), .sup_above_hi(sup_above_hi),
    .sup_below_lo(sup_below_lo), .gate_en(gate_en), .soft_dis_en(soft_dis_en),
    .hard_pd_en(hard_pd_en), .clamp_en(clamp_en), .fault_n(fault_n)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle model of the requirements: 0 off,1 blank,2 on,3 soft,4 hard,5 rearm
  int m_st = 0, m_bc = 0, m_mc = 0;
  bit m_lock = 1, m_clamp = 1;

  function automatic bit m_gate(input int s); return s == 1 || s == 2; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_bc = 0; m_mc = 0; m_lock = 1; m_clamp = 1;
    end else begin
      int n;
      n = m_st;
      case (m_st)
        0: if (cmd_on && !m_lock) begin n = 1; m_bc = 0; end
        1: if (!cmd_on || m_lock) n = 0;
           else if (m_bc == BLANK - 1) n = 2;
           else m_bc++;
        2: if (desat_hi) begin n = 3; m_mc = 0; end
           else if (!cmd_on || m_lock) n = 0;
        3: begin if (m_mc < MUTE - 1) m_mc++; if (gate_below_lo) n = 4; end
        4: if (m_mc >= MUTE - 1) n = 5; else m_mc++;
        default: if (!cmd_on) n = 0;
      endcase
      if (m_gate(n)) m_clamp = 0; else if (gate_below_lo) m_clamp = 1;
      m_st = n;
      if (sup_below_lo) m_lock = 1; else if (sup_above_hi) m_lock = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1 gate_en", gate_en, m_gate(m_st));
      chk("R2 fault_n", fault_n, !(m_st == 3 || m_st == 4));
      chk("R4 soft_dis_en", soft_dis_en, m_st == 3);
      chk("R5 hard_pd_en", hard_pd_en, m_st == 4);
      chk("R8 clamp_en", clamp_en, m_clamp);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R12 reset state
    chk("R12 gate", gate_en, 0); chk("R12 fault", fault_n, 1);
    chk("R12 clamp", clamp_en, 1); chk("R12 soft", soft_dis_en, 0);
    chk("R12 hard", hard_pd_en, 0);
    cmd_on = 1; tick(3);
    chk("R12 lockout engaged", gate_en, 0);
    sup_above_hi = 1; tick(1);
    chk("R9 release latency", gate_en, 0);
    tick(1);
    chk("R1 turn on", gate_en, 1); chk("R8 clamp drops", clamp_en, 0);
    sup_above_hi = 0;
    // R3 / R11 blanking
    desat_hi = 1; tick(BLANK);
    chk("R3 blank fault_n", fault_n, 1); chk("R11 blank soft", soft_dis_en, 0);
    tick(1);
    chk("R4 fault", fault_n, 0); chk("R4 soft", soft_dis_en, 1); chk("R4 gate", gate_en, 0);
    desat_hi = 0;
    // R6 command ignored
    cmd_on = 0; tick(1); cmd_on = 1; tick(2);
    chk("R6 gate", gate_en, 0); chk("R6 fault", fault_n, 0);
    tick(MUTE + 4);
    chk("R7 soft completes", fault_n, 0); chk("R7 still soft", soft_dis_en, 1);
    gate_below_lo = 1; tick(1);
    chk("R5 hard", hard_pd_en, 1); chk("R5 soft off", soft_dis_en, 0);
    tick(1);
    chk("R7 release", fault_n, 1);
    gate_below_lo = 0; tick(5);
    chk("R10 held off", gate_en, 0); chk("R8 clamp set", clamp_en, 1);
    cmd_on = 0; tick(1); cmd_on = 1; tick(1);
    chk("R10 fresh edge", gate_en, 1); chk("R8 clamp clear", clamp_en, 0);
    tick(BLANK + 2);
    // R7 exact mute length
    desat_hi = 1; gate_below_lo = 1; tick(1);
    chk("R7 start", fault_n, 0);
    desat_hi = 0; tick(MUTE - 1);
    chk("R7 last low", fault_n, 0);
    tick(1);
    chk("R7 exact release", fault_n, 1);
    gate_below_lo = 0;
    cmd_on = 0; tick(1); cmd_on = 1; tick(1);
    tick(BLANK + 2);
    // R13 coincidence of desat and command off
    cmd_on = 0; desat_hi = 1; tick(1);
    chk("R13 fault wins", fault_n, 0); chk("R13 soft", soft_dis_en, 1);
    desat_hi = 0; gate_below_lo = 1; tick(MUTE + 2);
    chk("R7 release after R13", fault_n, 1);
    gate_below_lo = 0;
    // R9 hysteresis
    cmd_on = 1; tick(2);
    chk("R9 on before lock", gate_en, 1);
    sup_below_lo = 1; tick(1);
    chk("R9 lock latency", gate_en, 1);
    tick(1);
    chk("R9 lock engaged", gate_en, 0);
    sup_below_lo = 0; tick(4);
    chk("R9 lock holds", gate_en, 0);
    sup_below_lo = 1; sup_above_hi = 1; tick(3);
    chk("R9 below wins", gate_en, 0);
    sup_below_lo = 0; tick(1);
    chk("R9 release latency", gate_en, 0);
    tick(1);
    chk("R9 released", gate_en, 1);
    sup_above_hi = 0;
    // R11 desat with gate off
    cmd_on = 0; tick(1);
    chk("R1 cmd off", gate_en, 0);
    desat_hi = 1; tick(4);
    chk("R11 off fault", fault_n, 1); chk("R11 off soft", soft_dis_en, 0);
    desat_hi = 0;
    // random phase
    for (int i = 0; i < 6000; i++) begin
      if (($urandom % 16) == 0) cmd_on = ~cmd_on;
      desat_hi      = (($urandom % 6) == 0);
      gate_below_lo = (($urandom % 4) == 0);
      sup_above_hi  = (($urandom % 3) == 0);
      sup_below_lo  = (($urandom % 40) == 0);
      tick(1);
    end
    summary();
  end
endmodule